// File: doc/BRIEF.md
# SAT Variable State Table

This block holds the global state of every variable in a satisfiability search that works on one partition ("bin") of clauses at a time. Each variable has one record. The record holds:

- whether the variable has been decided;
- a 2-bit value;
- whether the value was implied or chosen;
- the decision level;
- the bin in which the decision was made.

A single backtrack marker is kept beside the records, and it always names one variable at most.

The surrounding solver uses the table in five ways:

- It reads and writes single records.
- It commits the states of the active bin's variables when that bin turns out consistent.
- It erases, in one sweep, every decision made above a chosen level.
- It keeps the marker up to date.
- It asks the table for the backtrack target. The solver supplies a mask of conflicting variables. The table returns the masked, decided variable with the highest level, together with that variable's bin. It also returns a flag that says whether that bin is the active bin, which tells the solver whether it can stay in the active bin or must return to an earlier one.

The bulk cancel visits one record per clock. Reads issued while it runs are held until it finishes. All storage is kept in registers.

Top module: `sat_var_table`

## Requirements
- R1: After reset, every record reads as undecided. The marker is empty, the sweep is idle, and `rd_valid`, `sr_valid` and `cx_done` are low.
- R2: A read issued while no sweep runs returns, on the next clock, the record at `rd_idx` as it stood at issue. The record gives the decided flag, the value, the implied flag, the level and the bin. The `rd_mark` output is high when the marker names that index. A single write replaces all five fields of the record at `wr_idx`.
- R3: A commit updates every variable whose `cm_mask` bit is set. Variable i takes its decided flag from `cm_decided[i]`, its value from `cm_val[2i+1:2i]`, its implied flag from `cm_implied[i]` and its level from `cm_level[LW*i +: LW]`. The bin field becomes `cm_bin` only when the record goes from undecided to decided; otherwise the stored bin is kept. Variables outside the mask are unchanged.
- R4: A `cx_start` accepted while idle raises `cx_busy` on the next clock. The sweep then visits one record per clock, in ascending index. Each decided record whose level is above `cx_level` is returned to undecided, with all of its fields cleared to zero. If the marker names a record that the sweep clears, the marker is emptied. `cx_done` is a one-cycle pulse that appears NV clocks after the start edge, together with `cx_busy` falling. Records whose level is at or below `cx_level` are left untouched. A `cx_start` that arrives while a sweep is running is ignored.
- R5: A read issued while the sweep runs does not return while the sweep is busy. It is answered on the clock after `cx_done`, with the contents after the sweep. Only the latest read issued during the sweep is held.
- R6: Several updates may target the same index on the same clock. A single write wins over a commit and over the sweep's clear. A commit wins over the sweep's clear.
- R7: The marker names the lowest-indexed variable flagged so far. A set with an index below the current holder moves the marker to that index. A set with a higher index is ignored. A clear empties the marker. A set on the same clock as a clear leaves the set's index as the holder.
- R8: One clock after `sr_en`, the search result is returned. It gives the index, level and bin of the masked, decided variable with the highest level, using the table as it stood at issue. Ties on level go to the lowest index. `sr_local` is high when the target's bin equals `cur_bin`.
- R9: A search whose mask selects no decided variable returns `sr_none` high and `sr_local` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-record write strobe |
| wr_idx | input | IW | Variable index to write |
| wr_decided | input | 1 | Decided flag to write |
| wr_val | input | 2 | Value to write |
| wr_implied | input | 1 | Implied flag to write |
| wr_level | input | LW | Decision level to write |
| wr_bin | input | BW | Bin index to write |
| rd_en | input | 1 | Read request |
| rd_idx | input | IW | Variable index to read |
| rd_valid | output | 1 | Read result valid |
| rd_decided | output | 1 | Decided flag read |
| rd_val | output | 2 | Value read |
| rd_implied | output | 1 | Implied flag read |
| rd_level | output | LW | Level read |
| rd_bin | output | BW | Bin read |
| rd_mark | output | 1 | Marker names the variable that was read |
| cm_en | input | 1 | Commit strobe for the active bin |
| cm_bin | input | BW | Index of the active bin |
| cm_mask | input | NV | Variables that belong to the active bin |
| cm_decided | input | NV | Decided flag of each variable |
| cm_val | input | 2*NV | Value of each variable |
| cm_implied | input | NV | Implied flag of each variable |
| cm_level | input | LW*NV | Level of each variable |
| cx_start | input | 1 | Start of a bulk cancel |
| cx_level | input | LW | Records above this level are cancelled |
| cx_busy | output | 1 | Sweep in progress |
| cx_done | output | 1 | Sweep finished (one-cycle pulse) |
| mk_set | input | 1 | Flag a variable for the marker |
| mk_clr | input | 1 | Empty the marker |
| mk_idx | input | IW | Index to flag |
| mk_valid | output | 1 | Marker holds a variable |
| mk_holder | output | IW | Variable holding the marker |
| sr_en | input | 1 | Search request |
| sr_mask | input | NV | Conflicting variables to search |
| cur_bin | input | BW | Active bin, compared with the target's bin |
| sr_valid | output | 1 | Search result valid |
| sr_none | output | 1 | No decided variable in the mask |
| sr_idx | output | IW | Index of the target |
| sr_level | output | LW | Level of the target |
| sr_bin | output | BW | Bin of the target |
| sr_local | output | 1 | Target was decided in the active bin |

## Verification
The bench issues each request at a falling edge and reads the result at the falling edge after the clock edge that registers it.

- **Reads and searches:** the result is due one clock after issue, so the bench samples at the next falling edge.
- **Sweep:** `cx_done` must be high exactly at the NV-th falling edge after the start edge, and low before it. A read issued during the sweep must stay unanswered until the falling edge one later than `cx_done`. The bench checks each sample point in turn.
- **Writes, commits and marker updates:** these take effect on the next edge. The bench observes them through a read, a search or the marker outputs.

The search is swept over every mask of an eight-variable table. The bench compares each result against a reference model that it maintains itself.

// File: rtl/sat_var_table.sv
module sat_var_table #(
  parameter int NV = 16,
  parameter int NB = 4,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1,
  localparam int LW = IW,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_decided,
  input  logic [1:0]      wr_val,
  input  logic            wr_implied,
  input  logic [LW-1:0]   wr_level,
  input  logic [BW-1:0]   wr_bin,
  input  logic            rd_en,
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_valid,
  output logic            rd_decided,
  output logic [1:0]      rd_val,
  output logic            rd_implied,
  output logic [LW-1:0]   rd_level,
  output logic [BW-1:0]   rd_bin,
  output logic            rd_mark,
  input  logic            cm_en,
  input  logic [BW-1:0]   cm_bin,
  input  logic [NV-1:0]   cm_mask,
  input  logic [NV-1:0]   cm_decided,
  input  logic [2*NV-1:0] cm_val,
  input  logic [NV-1:0]   cm_implied,
  input  logic [LW*NV-1:0] cm_level,
  input  logic            cx_start,
  input  logic [LW-1:0]   cx_level,
  output logic            cx_busy,
  output logic            cx_done,
  input  logic            mk_set,
  input  logic            mk_clr,
  input  logic [IW-1:0]   mk_idx,
  output logic            mk_valid,
  output logic [IW-1:0]   mk_holder,
  input  logic            sr_en,
  input  logic [NV-1:0]   sr_mask,
  input  logic [BW-1:0]   cur_bin,
  output logic            sr_valid,
  output logic            sr_none,
  output logic [IW-1:0]   sr_idx,
  output logic [LW-1:0]   sr_level,
  output logic [BW-1:0]   sr_bin,
  output logic            sr_local
);

  logic          dec_q [NV];
  logic [1:0]    val_q [NV];
  logic          imp_q [NV];
  logic [LW-1:0] lvl_q [NV];
  logic [BW-1:0] bin_q [NV];

  logic [IW-1:0] ptr_q;
  logic [LW-1:0] thr_q;
  logic          rd_pend_q;
  logic [IW-1:0] rd_pidx_q;

  // sweep clear of the record under the pointer
  function automatic logic sweep_hit(input int i);
    return cx_busy && (ptr_q == IW'(i)) && dec_q[i] && (lvl_q[i] > thr_q);
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NV; i++) begin
      if (!rst_n) begin
        dec_q[i] <= 1'b0;
        val_q[i] <= '0;
        imp_q[i] <= 1'b0;
        lvl_q[i] <= '0;
        bin_q[i] <= '0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        dec_q[i] <= wr_decided;
        val_q[i] <= wr_val;
        imp_q[i] <= wr_implied;
        lvl_q[i] <= wr_level;
        bin_q[i] <= wr_bin;
      end else if (cm_en && cm_mask[i]) begin
        dec_q[i] <= cm_decided[i];
        val_q[i] <= cm_val[2*i +: 2];
        imp_q[i] <= cm_implied[i];
        lvl_q[i] <= cm_level[LW*i +: LW];
        if (cm_decided[i] && !dec_q[i]) bin_q[i] <= cm_bin;
      end else if (sweep_hit(i)) begin
        dec_q[i] <= 1'b0;
        val_q[i] <= '0;
        imp_q[i] <= 1'b0;
        lvl_q[i] <= '0;
        bin_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx_busy <= 1'b0;
      cx_done <= 1'b0;
      ptr_q   <= '0;
      thr_q   <= '0;
    end else begin
      cx_done <= 1'b0;
      if (cx_busy) begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == IW'(NV - 1)) begin
          cx_busy <= 1'b0;
          cx_done <= 1'b1;
        end
      end else if (cx_start) begin
        cx_busy <= 1'b1;
        ptr_q   <= '0;
        thr_q   <= cx_level;
      end
    end
  end

  logic          rd_serve;
  logic [IW-1:0] rd_sel;
  assign rd_serve = !cx_busy && (rd_en || rd_pend_q);
  assign rd_sel   = rd_pend_q ? rd_pidx_q : rd_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      rd_pidx_q  <= '0;
      rd_valid   <= 1'b0;
      rd_decided <= 1'b0;
      rd_val     <= '0;
      rd_implied <= 1'b0;
      rd_level   <= '0;
      rd_bin     <= '0;
      rd_mark    <= 1'b0;
    end else begin
      rd_valid <= rd_serve;
      if (cx_busy && rd_en) begin
        rd_pend_q <= 1'b1;
        rd_pidx_q <= rd_idx;
      end else if (rd_serve) begin
        rd_pend_q <= 1'b0;
      end
      if (rd_serve) begin
        rd_decided <= dec_q[rd_sel];
        rd_val     <= val_q[rd_sel];
        rd_implied <= imp_q[rd_sel];
        rd_level   <= lvl_q[rd_sel];
        rd_bin     <= bin_q[rd_sel];
        rd_mark    <= mk_valid && (mk_holder == rd_sel);
      end
    end
  end

  logic hold_kill, hold_live, hold_take;
  assign hold_kill = mk_valid && sweep_hit(int'(mk_holder)) &&
                     !(wr_en && wr_idx == mk_holder) &&
                     !(cm_en && cm_mask[mk_holder]);
  assign hold_live = mk_valid && !hold_kill && !mk_clr;
  assign hold_take = mk_set && (!hold_live || mk_idx < mk_holder);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_valid  <= 1'b0;
      mk_holder <= '0;
    end else begin
      mk_valid <= hold_live || mk_set;
      if (hold_take) mk_holder <= mk_idx;
    end
  end

  logic          best_f;
  logic [IW-1:0] best_i;
  logic [LW-1:0] best_l;

  always_comb begin
    best_f = 1'b0;
    best_i = '0;
    best_l = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (sr_mask[i] && dec_q[i] && (!best_f || lvl_q[i] >= best_l)) begin
        best_f = 1'b1;
        best_i = IW'(i);
        best_l = lvl_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_valid <= 1'b0;
      sr_none  <= 1'b0;
      sr_idx   <= '0;
      sr_level <= '0;
      sr_bin   <= '0;
      sr_local <= 1'b0;
    end else begin
      sr_valid <= sr_en;
      if (sr_en) begin
        sr_none  <= !best_f;
        sr_idx   <= best_i;
        sr_level <= best_l;
        sr_bin   <= bin_q[best_i];
        sr_local <= best_f && (bin_q[best_i] == cur_bin);
      end
    end
  end

endmodule

// File: rtl/sat_var_table_chk.sv
module sat_var_table_chk #(
  parameter int NV = 16,
  parameter int NB = 4,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
)(
  input logic          clk,
  input logic          rst_n,
  input logic          cx_start,
  input logic          cx_busy,
  input logic          cx_done,
  input logic          rd_valid,
  input logic          sr_en,
  input logic          sr_valid,
  input logic          mk_set,
  input logic          mk_clr,
  input logic [IW-1:0] mk_idx,
  input logic          mk_valid,
  input logic [IW-1:0] mk_holder
);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cx_start && !cx_busy |=> cx_busy);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cx_done |=> !cx_done);

  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cx_done |-> !cx_busy && $past(cx_busy));

  p_read_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(cx_busy));

  p_search_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_en |=> sr_valid);

  p_mark_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mk_set && !mk_clr && mk_valid && !cx_busy |=>
      mk_valid && mk_holder == (($past(mk_idx) < $past(mk_holder)) ? $past(mk_idx) : $past(mk_holder)));

  p_mark_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mk_clr && !mk_set |=> !mk_valid);

endmodule

bind sat_var_table sat_var_table_chk #(.NV(NV), .NB(NB)) chk_i (.*);

// File: tb/sat_var_table_tb_top.sv
module sat_var_table_tb_top;
  localparam int NV = 8;
  localparam int NB = 4;
  localparam int IW = 3;
  localparam int LW = 3;
  localparam int BW = 2;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  always #(PERIOD/2) clk = ~clk;

  logic wr_en = 0, wr_decided = 0, wr_implied = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [1:0] wr_val = 0;
  logic [LW-1:0] wr_level = 0;
  logic [BW-1:0] wr_bin = 0;
  logic rd_en = 0;
  logic [IW-1:0] rd_idx = 0;
  logic rd_valid, rd_decided, rd_implied, rd_mark;
  logic [1:0] rd_val;
  logic [LW-1:0] rd_level;
  logic [BW-1:0] rd_bin;
  logic cm_en = 0;
  logic [BW-1:0] cm_bin = 0;
  logic [NV-1:0] cm_mask = 0, cm_decided = 0, cm_implied = 0;
  logic [2*NV-1:0] cm_val = 0;
  logic [LW*NV-1:0] cm_level = 0;
  logic cx_start = 0;
  logic [LW-1:0] cx_level = 0;
  logic cx_busy, cx_done;
  logic mk_set = 0, mk_clr = 0;
  logic [IW-1:0] mk_idx = 0;
  logic mk_valid;
  logic [IW-1:0] mk_holder;
  logic sr_en = 0;
  logic [NV-1:0] sr_mask = 0;
  logic [BW-1:0] cur_bin = 0;
  logic sr_valid, sr_none, sr_local;
  logic [IW-1:0] sr_idx;
  logic [LW-1:0] sr_level;
  logic [BW-1:0] sr_bin;

  sat_var_table #(.NV(NV), .NB(NB)) dut_i (.*);

  int md[NV], mv[NV], mi[NV], ml[NV], mb[NV];
  int mhv = 0, mho = 0;
  int vecs = 0, miss = 0;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int pack_rec(int d, int v, int im, int l, int b, int mk);
    return d ? ((1 << 12) | (v << 10) | (im << 9) | (l << 4) | (b << 1) | mk) : mk;
  endfunction

  task automatic read_chk(input int i, input string tag);
    rd_en = 1; rd_idx = IW'(i);
    tick();
    rd_en = 0;
    chk({tag, " rd_valid"}, int'(rd_valid), 1);
    chk(tag, pack_rec(rd_decided, rd_val, rd_implied, rd_level, rd_bin, rd_mark),
        pack_rec(md[i], mv[i], mi[i], ml[i], mb[i], int'(mhv != 0 && mho == i)));
  endtask

  task automatic write_rec(input int i, input int d, input int v, input int im, input int l, input int b);
    wr_en = 1; wr_idx = IW'(i); wr_decided = d[0]; wr_val = v[1:0];
    wr_implied = im[0]; wr_level = l[LW-1:0]; wr_bin = b[BW-1:0];
    tick();
    wr_en = 0;
    md[i] = d; mv[i] = v; mi[i] = im; ml[i] = l; mb[i] = b;
  endtask

  task automatic mark_op(input int set, input int clr, input int idx);
    mk_set = set[0]; mk_clr = clr[0]; mk_idx = IW'(idx);
    tick();
    mk_set = 0; mk_clr = 0;
    if (clr != 0) mhv = 0;
    if (set != 0 && (mhv == 0 || idx < mho)) mho = idx;
    if (set != 0) mhv = 1;
  endtask

  task automatic search_chk(input int mask, input int cb);
    int f = 0, bi = 0, bl = 0, e;
    for (int i = 0; i < NV; i++)
      if (mask[i] && md[i] != 0 && (f == 0 || ml[i] > bl)) begin f = 1; bi = i; bl = ml[i]; end
    sr_en = 1; sr_mask = mask[NV-1:0]; cur_bin = cb[BW-1:0];
    tick();
    sr_en = 0;
    e = f ? ((bi << 8) | (bl << 4) | (mb[bi] << 1) | int'(mb[bi] == cb)) : (1 << 12);
    chk($sformatf("R8/R9 search mask=%0h", mask), sr_valid ?
        (sr_none ? (1 << 12) : ((sr_idx << 8) | (sr_level << 4) | (sr_bin << 1) | sr_local)) : -1, e);
  endtask

  // cancel sweep; pri!=0 adds a same-cycle write at 4 and commit at 6 (R6)
  task automatic cancel_run(input int thr, input int pri);
    int ob6;
    ob6 = mb[6];
    cx_start = 1; cx_level = thr[LW-1:0];
    tick();
    cx_start = 0;
    chk("R4 busy after start", int'(cx_busy), 1);
    for (int n = 0; n <= NV + 1; n++) begin
      chk($sformatf("R4 done at n=%0d", n), int'(cx_done), int'(n == NV));
      if (n <= NV) chk($sformatf("R5 stall n=%0d", n), int'(rd_valid), 0);
      if (n == NV + 1) begin
        chk("R5 stalled read valid", int'(rd_valid), 1);
        chk("R5 stalled read decided", int'(rd_decided), (pri != 0) ? 0 : int'(ml[7] <= thr));
        break;
      end
      rd_en = (n == 1); rd_idx = 7;
      wr_en = (pri != 0 && n == 4); wr_idx = 4; wr_decided = 1; wr_val = 2;
      wr_implied = 1; wr_level = 6; wr_bin = 3;
      cm_en = (pri != 0 && n == 6); cm_mask = 8'h40; cm_decided = 8'h40;
      cm_val = 16'h2000; cm_implied = 0; cm_level = 24'(5) << (LW*6); cm_bin = 0;
      tick();
      rd_en = 0; wr_en = 0; cm_en = 0;
    end
    for (int i = 0; i < NV; i++)
      if (md[i] != 0 && ml[i] > thr) begin
        md[i] = 0; mv[i] = 0; mi[i] = 0; ml[i] = 0; mb[i] = 0;
        if (mhv != 0 && mho == i) mhv = 0;
      end
    if (pri != 0) begin
      md[4] = 1; mv[4] = 2; mi[4] = 1; ml[4] = 6; mb[4] = 3;
      md[6] = 1; mv[6] = 2; mi[6] = 0; ml[6] = 5; mb[6] = ob6;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    miss++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin md[i] = 0; mv[i] = 0; mi[i] = 0; ml[i] = 0; mb[i] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 busy idle", int'(cx_busy), 0);
    chk("R1 done low", int'(cx_done), 0);
    chk("R1 marker empty", int'(mk_valid), 0);
    chk("R1 search idle", int'(sr_valid), 0);
    chk("R1 read idle", int'(rd_valid), 0);
    for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R1 reset rec %0d", i));

    // R2 write/read
    for (int i = 0; i < NV; i++) write_rec(i, 1, i % 3, i & 1, (i * 5) % 8, i % 4);
    for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R2 rec %0d", i));
    write_rec(3, 0, 0, 0, 0, 0);
    write_rec(5, 1, 1, 0, 7, 2);
    for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R2 rewrite rec %0d", i));

    // R8/R9 exhaustive search, two active bins
    for (int m = 0; m < (1 << NV); m++) search_chk(m, 1);
    for (int m = 0; m < (1 << NV); m += 7) search_chk(m, 2);

    // R7 marker
    mark_op(1, 0, 5);
    chk("R7 set first", (int'(mk_valid) << 4) | mk_holder, (1 << 4) | 5);
    mark_op(1, 0, 6);
    chk("R7 higher ignored", (int'(mk_valid) << 4) | mk_holder, (1 << 4) | 5);
    mark_op(1, 0, 2);
    chk("R7 lower moves", (int'(mk_valid) << 4) | mk_holder, (1 << 4) | 2);
    read_chk(2, "R7 rd_mark holder");
    read_chk(5, "R7 rd_mark non-holder");
    mark_op(0, 1, 0);
    chk("R7 clear", int'(mk_valid), 0);
    mark_op(1, 0, 4);
    mark_op(1, 1, 6);
    chk("R7 set with clear", (int'(mk_valid) << 4) | mk_holder, (1 << 4) | 6);

    // R3 commit
    cm_en = 1; cm_bin = 3; cm_mask = 8'b1010_1101; cm_decided = 8'b1110_1001;
    cm_implied = 8'b0101_0101; cm_val = 16'h1B6C; cm_level = 24'o76543210;
    tick();
    cm_en = 0;
    for (int i = 0; i < NV; i++)
      if (cm_mask[i]) begin
        if (cm_decided[i] && md[i] == 0) mb[i] = 3;
        md[i] = cm_decided[i]; mv[i] = cm_val[2*i +: 2];
        mi[i] = cm_implied[i]; ml[i] = cm_level[LW*i +: LW];
      end
    for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R3 commit rec %0d", i));

    // R6 write beats commit, same index same cycle
    wr_en = 1; wr_idx = 2; wr_decided = 1; wr_val = 1; wr_implied = 0; wr_level = 1; wr_bin = 1;
    cm_en = 1; cm_mask = 8'h04; cm_decided = 8'h04; cm_level = 24'(4) << (LW*2); cm_bin = 2;
    tick();
    wr_en = 0; cm_en = 0;
    md[2] = 1; mv[2] = 1; mi[2] = 0; ml[2] = 1; mb[2] = 1;
    read_chk(2, "R6 write over commit");

    // R4/R5 cancel at every threshold
    for (int t = 0; t < NV; t++) begin
      for (int i = 0; i < NV; i++) write_rec(i, 1, (i + t) % 4, i & 1, i, (i + t) % 4);
      mark_op(0, 1, 0);
      mark_op(1, 0, 7);
      cancel_run(t, 0);
      chk($sformatf("R4 marker after thr %0d", t), int'(mk_valid), mhv);
      for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R4 thr %0d rec %0d", t, i));
    end

    // R6 write and commit beat the sweep
    for (int i = 0; i < NV; i++) write_rec(i, 1, 1, 0, (i % 7) + 1, i % 4);
    cancel_run(0, 1);
    for (int i = 0; i < NV; i++) read_chk(i, $sformatf("R6 sweep priority rec %0d", i));

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule